// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block gathers one-clock interrupt pulses from a row of peripheral sources and holds each in a sticky request bit. Every source has a two-bit priority level. Level 0 parks the source: its request still latches, but it never wins. The lowest source indices are trap inputs whose level is wired to 3 and cannot be changed. Each clock, an arbiter picks the best pending request. A higher level always beats a lower one, and within a level the lower source index wins. The arbiter offers the winner's index to the CPU as a registered vector.

The CPU side is a valid/ready pair. `irq_valid` is high while the global enable is set and at least one request with a nonzero level is pending. `irq_ack` is the ready. A transfer happens on a clock where both are high. On that clock the request bit named by `irq_vector` clears, and so does the global enable. `irq_ack` has no effect while `irq_valid` is low. While the CPU holds off, `irq_valid` stays high unless software or a disable command takes the condition away. `irq_vector` may move to a better winner that arrives in the meantime, because the vector always names the current best request.

Software reaches the block over a simple synchronous bus. The bus writes on `bus_we` and reads back combinationally through `bus_rdata`. Every write takes effect on the clock it occurs. This lets software clear single request bits without losing pulses that arrive at the same time.

Top module: `prio_intc`

## Requirements
- R1: After reset, the request register (address 0) reads 0, the control register (address 1) reads 0, and every non-trap level register reads 0. Trap level registers read 3, and `irq_valid` is 0.
- R2: A one-clock high on `src_pulse[i]` sets request bit i (address 0, bit i). The bit stays set afterwards with no further pulse.
- R3: Among pending requests with a nonzero level, a higher level always wins, whatever the source index.
- R4: Among pending requests at the same level, the lowest source index wins.
- R5: Sources 0 to NTRAP-1 are traps. Their level register (address 2+i, bits 1:0) always reads 3, and writes to it are ignored.
- R6: A source whose level is 0 still latches its request, but it never drives `irq_valid` or the vector.
- R7: A transfer (`irq_valid` and `irq_ack` both high) clears the request bit named by `irq_vector` and clears the global enable (address 1, bit 0). `irq_ack` while `irq_valid` is low changes nothing.
- R8: A bus write to address 0 sets each request bit to the written value on that clock. A `src_pulse` on the same clock overrides a written 0 for its bit.
- R9: Writing 1 or 0 to address 1, bit 0 sets or clears the global enable. A one-clock `di_strobe` clears it.
- R10: On the clock edge after any state change, `irq_valid` equals (global enable AND any eligible request pending), and `irq_vector` names the winner.
- R11: A `src_pulse` on the same clock as a transfer of that source leaves the request bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NSRC | One-clock request pulses, bit i is source i |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address: 0 request, 1 control, 2+i level of source i |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data at `bus_addr` |
| di_strobe | input | 1 | Disable-interrupt command, clears the global enable |
| irq_valid | output | 1 | Interrupt offered to the CPU |
| irq_ack | input | 1 | CPU accepts the offered interrupt (ready) |
| irq_vector | output | $clog2(NSRC) | Index of the winning source |

## Verification
The bench builds the block with NSRC=6, NTRAP=2, AW=4 and DW=8. Six sources are enough to hold two traps and four programmable sources at three different levels at once. With that many, every level comparison and every same-level tie can be set up in a few writes. The small address and data widths keep the whole register map, including the trap level registers that ignore writes, within direct reach of short read-back sequences.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_OFF = 2'd0;
  localparam lvl_t LVL_TOP = 2'd3;
  localparam int unsigned LVL_BASE = 2;
endpackage

// File: rtl/intc_req_bank.sv
module intc_req_bank #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned IW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pulse,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_data,
  input  logic            clr_en,
  input  logic [IW-1:0]   clr_idx,
  output logic [NSRC-1:0] req_d,
  output logic [NSRC-1:0] req_q
);
  // pulse beats bus write, bus write beats acknowledge clear
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      if (pulse[i])                         req_d[i] = 1'b1;
      else if (wr_en)                       req_d[i] = wr_data[i];
      else if (clr_en && clr_idx == IW'(i)) req_d[i] = 1'b0;
      else                                  req_d[i] = req_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/intc_level_regs.sv
module intc_level_regs
  import intc_pkg::*;
#(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned NTRAP = 2,
  parameter int unsigned IW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  lvl_t                 wr_lvl,
  output logic [NSRC-1:0][1:0] lvl_d,
  output logic [NSRC-1:0][1:0] lvl_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g < NTRAP) begin : g_trap
      assign lvl_d[g] = LVL_TOP;
      assign lvl_q[g] = LVL_TOP;
    end else begin : g_prog
      lvl_t cur_q;
      assign lvl_d[g] = (wr_en && wr_idx == IW'(g)) ? wr_lvl : cur_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= LVL_OFF;
        else        cur_q <= lvl_d[g];
      end
      assign lvl_q[g] = cur_q;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  parameter int unsigned IW   = 3
) (
  input  logic [NSRC-1:0]      req,
  input  logic [NSRC-1:0][1:0] lvl,
  output logic                 found,
  output logic [IW-1:0]        idx
);
  lvl_t best;
  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = LVL_OFF;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && lvl[i] != LVL_OFF && lvl[i] >= best) begin
        found = 1'b1;
        best  = lvl[i];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned NTRAP = 2,
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_pulse,
  input  logic                     bus_we,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic                     di_strobe,
  output logic                     irq_valid,
  input  logic                     irq_ack,
  output logic [$clog2(NSRC)-1:0]  irq_vector
);
  localparam int unsigned IW = $clog2(NSRC);

  logic            sel_req, sel_ctrl, sel_lvl;
  logic [IW-1:0]   lvl_idx;
  logic            xfer;
  logic [NSRC-1:0] req_d, req_q;
  logic [NSRC-1:0][1:0] lvl_d, lvl_q;
  logic            en_d, en_q;
  logic            found_d;
  logic [IW-1:0]   win_d;
  logic            valid_q;
  logic [IW-1:0]   vec_q;

  assign sel_req  = (bus_addr == AW'(0));
  assign sel_ctrl = (bus_addr == AW'(1));
  assign sel_lvl  = (bus_addr >= AW'(LVL_BASE)) && (bus_addr < AW'(LVL_BASE + NSRC));
  assign lvl_idx  = IW'(bus_addr - AW'(LVL_BASE));
  assign xfer     = valid_q && irq_ack;

  intc_req_bank #(.NSRC(NSRC), .IW(IW)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse   (src_pulse),
    .wr_en   (bus_we && sel_req),
    .wr_data (bus_wdata[NSRC-1:0]),
    .clr_en  (xfer),
    .clr_idx (vec_q),
    .req_d   (req_d),
    .req_q   (req_q)
  );

  intc_level_regs #(.NSRC(NSRC), .NTRAP(NTRAP), .IW(IW)) u_lvl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_we && sel_lvl),
    .wr_idx (lvl_idx),
    .wr_lvl (bus_wdata[1:0]),
    .lvl_d  (lvl_d),
    .lvl_q  (lvl_q)
  );

  // arbitrate on next-state so the registered offer tracks state exactly
  intc_arbiter #(.NSRC(NSRC), .IW(IW)) u_arb (
    .req   (req_d),
    .lvl   (lvl_d),
    .found (found_d),
    .idx   (win_d)
  );

  always_comb begin
    en_d = (bus_we && sel_ctrl) ? bus_wdata[0] : en_q;
    if (di_strobe || xfer) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      en_q    <= en_d;
      valid_q <= en_d && found_d;
      vec_q   <= win_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_req)       bus_rdata[NSRC-1:0] = req_q;
    else if (sel_ctrl) bus_rdata[0]        = en_q;
    else if (sel_lvl)  bus_rdata[1:0]      = lvl_q[lvl_idx];
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned NSRC = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSRC-1:0]         src_pulse,
  input logic                    di_strobe,
  input logic                    irq_valid,
  input logic                    irq_ack,
  input logic [$clog2(NSRC)-1:0] irq_vector,
  input logic                    en_q,
  input logic [NSRC-1:0]         req_q
);
  // R2
  pulse_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((req_q & $past(src_pulse)) == $past(src_pulse)));

  // R7
  xfer_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack) |=> !en_q);

  // R9
  di_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    di_strobe |=> !en_q);

  // R10
  valid_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> en_q);

  // R10
  vector_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> req_q[irq_vector]);
endmodule

bind prio_intc intc_chk #(.NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_pulse  (src_pulse),
  .di_strobe  (di_strobe),
  .irq_valid  (irq_valid),
  .irq_ack    (irq_ack),
  .irq_vector (irq_vector),
  .en_q       (en_q),
  .req_q      (req_q)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int CLK_P = 10;
  localparam int NSRC = 6, NTRAP = 2, AW = 4, DW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_pulse = '0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            di_strobe = 1'b0;
  logic            irq_valid;
  logic            irq_ack = 1'b0;
  logic [2:0]      irq_vector;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_intc #(.NSRC(NSRC), .NTRAP(NTRAP), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .di_strobe(di_strobe), .irq_valid(irq_valid), .irq_ack(irq_ack),
    .irq_vector(irq_vector)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    bus_addr = AW'(a); #1; d = int'(bus_rdata);
  endtask

  task automatic pulse(int m);
    src_pulse = NSRC'(m); tick(); src_pulse = '0;
  endtask

  task automatic t_reset();
    int d;
    rd(0, d); check("R1 req", d, 0);
    rd(1, d); check("R1 ctrl", d, 0);
    rd(5, d); check("R1 lvl3", d, 0);
    rd(2, d); check("R1 trap lvl", d, 3);
    check("R1 valid", int'(irq_valid), 0);
  endtask

  task automatic t_latch();
    int d;
    pulse(6'h10);
    tick();
    rd(0, d); check("R2 sticky", d, 6'h10);
    check("R10 valid with enable off", int'(irq_valid), 0);
  endtask

  task automatic t_priority();
    wr(4, 1); wr(5, 2); wr(6, 2); wr(7, 1);
    wr(1, 1);
    check("R10 valid", int'(irq_valid), 1);
    check("R10 vec", int'(irq_vector), 4);
    pulse(6'b101100);
    check("R4 tie lower index", int'(irq_vector), 3);
    wr(0, 6'h34);
    check("R8 write clears", int'(irq_vector), 4);
    wr(7, 3);
    check("R3 higher level", int'(irq_vector), 5);
  endtask

  task automatic t_trap();
    int d;
    wr(2, 0);
    rd(2, d); check("R5 trap fixed", d, 3);
    pulse(6'h02);
    check("R5 trap wins", int'(irq_vector), 1);
  endtask

  task automatic t_ack();
    int d;
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    rd(0, d); check("R7 req cleared", d, 6'h34);
    rd(1, d); check("R7 enable cleared", d, 0);
    check("R7 valid low", int'(irq_valid), 0);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    rd(0, d); check("R7 ack ignored", d, 6'h34);
  endtask

  task automatic t_enable();
    int d;
    wr(1, 1);
    check("R9 set", int'(irq_valid), 1);
    check("R9 vec", int'(irq_vector), 5);
    wr(1, 0);
    check("R9 clear", int'(irq_valid), 0);
    wr(1, 1);
    di_strobe = 1'b1; tick(); di_strobe = 1'b0;
    rd(1, d); check("R9 di ctrl", d, 0);
    check("R9 di valid", int'(irq_valid), 0);
  endtask

  task automatic t_level0();
    int d;
    wr(4, 0); wr(0, 0); wr(1, 1);
    pulse(6'h04);
    rd(0, d); check("R6 latched", d, 6'h04);
    check("R6 not offered", int'(irq_valid), 0);
    wr(4, 1);
    check("R6 offered after level", int'(irq_valid), 1);
    check("R6 vec", int'(irq_vector), 2);
  endtask

  task automatic t_race();
    int d;
    src_pulse = 6'h10; bus_we = 1'b1; bus_addr = 0; bus_wdata = 0;
    tick();
    src_pulse = '0; bus_we = 1'b0;
    rd(0, d); check("R8 pulse beats clear", d, 6'h10);
    check("R8 vec", int'(irq_vector), 4);
    src_pulse = 6'h10; irq_ack = 1'b1; tick(); src_pulse = '0; irq_ack = 1'b0;
    rd(0, d); check("R11 stays set", d, 6'h10);
    rd(1, d); check("R11 enable cleared", d, 0);
  endtask

  task automatic t_swset();
    int d;
    wr(1, 1);
    wr(0, 6'h08);
    rd(0, d); check("R8 write sets", d, 6'h08);
    check("R8 sw vec", int'(irq_vector), 3);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_latch();
    t_priority();
    t_trap();
    t_ack();
    t_enable();
    t_level0();
    t_race();
    t_swset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule